// File: doc/BRIEF.md
# Masked Compressed Index Vector Generator

This block builds the index vector that a gather or scatter operation of a 64-element vector unit uses. It is given a stride and a 64-bit element mask. It walks the element positions from 0 upward, one position per clock. For every position whose mask bit is set, it writes the value position × stride into a destination index register. These entries are packed densely, starting at slot 0. When the mask is all ones, the result is the plain ramp 0, stride, 2·stride, and so on.

At the end of the walk the block reports how many mask bits were set. Software can load this count as the new vector length, so that later indexed loads and stores touch only the selected elements. A single-cycle start request launches an operation. A busy flag covers the walk, and a one-cycle done pulse ends it. The destination register is reached through a write port that carries an enable, a slot number and the data.

Top module: `cidx_gen`

## Requirements
- R1: After a synchronous reset, busy_o, done_o and wr_en_o are 0 and count_o is 0.
- R2: A start_i pulse seen while idle captures stride_i and mask_i. busy_o is then high for exactly 64 consecutive cycles, and each of those cycles handles one element position, in ascending order from 0 to 63.
- R3: The data written for position i is i × stride, computed as 64-bit unsigned and wrapping modulo 2^64.
- R4: Writes go to slots 0, 1, 2, … in the order of ascending position. The slot number advances only after a write.
- R5: A position whose mask bit is 0 produces no write. Consequently no slot at or above the population count is written.
- R6: With an all-ones mask, slot k receives k × stride for every k from 0 to 63.
- R7: done_o is high for exactly one cycle, namely the cycle after the last busy cycle. busy_o is low on that cycle.
- R8: On the done cycle, count_o equals the number of 1 bits in the captured mask, from 0 up to 64. The value stays held until the next accepted start.
- R9: A start_i pulse while busy is ignored. The operands are not replaced and the timing of the running operation does not change.
- R10: Asserting rst during an operation returns the block to idle on the next cycle. It raises no done pulse and makes no further writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch request, honoured only when idle |
| stride_i | input | 64 | Stride operand |
| mask_i | input | 64 | Element mask, bit i selects position i |
| busy_o | output | 1 | High while positions are being walked |
| done_o | output | 1 | One-cycle completion pulse |
| count_o | output | 7 | Number of set mask bits (new vector length) |
| wr_en_o | output | 1 | Destination register write enable |
| wr_slot_o | output | 6 | Destination slot number |
| wr_data_o | output | 64 | Index value to write |

## Verification
The assertions assume that the captured stride and mask stay fixed for the whole walk. They also assume that the destination side accepts a write every cycle without back-pressure, because the block has no stall input. The stimulus holds start_i for one cycle per launch. It raises start_i again mid-walk with different operands, to show that those operands are never taken up. Reset is asserted mid-walk only as a deliberate directed case. Strides are drawn at random over the full 64-bit range, including all-ones values so that the multiplication wraps. Masks mix random patterns with the empty, full, single-bit and alternating corner cases.

// File: rtl/cidx_pkg.sv
package cidx_pkg;

    // walk sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

    // command from sequencer to datapath
    typedef struct packed {
        logic load;   // capture operands, clear counters
        logic step;   // process one element position
    } seq_cmd_t;

    // width of a counter able to hold 0..n
    function automatic int unsigned cnt_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cidx_ctrl.sv
module cidx_ctrl
    import cidx_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 64,
    localparam int unsigned POS_W   = $clog2(NUM_ELEM)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    output seq_cmd_t cmd_o,
    output logic     busy_o,
    output logic     done_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_ELEM - 1);

    seq_state_e       state_q, state_d;
    logic [POS_W-1:0] pos_q;

    always_comb begin
        state_d    = state_q;
        cmd_o.load = 1'b0;
        cmd_o.step = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    cmd_o.load = 1'b1;
                    state_d    = SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                cmd_o.step = 1'b1;
                if (pos_q == LAST_POS) state_d = SEQ_FIN;
            end
            SEQ_FIN:  state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cmd_o.load)      pos_q <= '0;
            else if (cmd_o.step) pos_q <= pos_q + 1'b1;
        end
    end

    assign busy_o = (state_q == SEQ_RUN);
    assign done_o = (state_q == SEQ_FIN);
endmodule

// File: rtl/cidx_ramp.sv
module cidx_ramp
    import cidx_pkg::*;
#(
    parameter int unsigned IDX_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_cmd_t         cmd_i,
    input  logic [IDX_W-1:0] stride_i,
    output logic [IDX_W-1:0] stride_o,
    output logic [IDX_W-1:0] value_o
);
    logic [IDX_W-1:0] stride_q, acc_q;

    // acc holds pos*stride for the current position; wraps naturally
    always_ff @(posedge clk) begin
        if (rst) begin
            stride_q <= '0;
            acc_q    <= '0;
        end else if (cmd_i.load) begin
            stride_q <= stride_i;
            acc_q    <= '0;
        end else if (cmd_i.step) begin
            acc_q    <= acc_q + stride_q;
        end
    end

    assign stride_o = stride_q;
    assign value_o  = acc_q;
endmodule

// File: rtl/cidx_pack.sv
module cidx_pack
    import cidx_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 64,
    localparam int unsigned POS_W   = $clog2(NUM_ELEM),
    localparam int unsigned CNT_W   = $clog2(NUM_ELEM + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_cmd_t         cmd_i,
    input  logic [NUM_ELEM-1:0] mask_i,
    output logic             wr_en_o,
    output logic [POS_W-1:0] wr_slot_o,
    output logic [CNT_W-1:0] count_o
);
    logic [NUM_ELEM-1:0] mask_q;
    logic [CNT_W-1:0]    slot_q;

    // mask shifts right each step so the current bit is always bit 0
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            slot_q <= '0;
        end else if (cmd_i.load) begin
            mask_q <= mask_i;
            slot_q <= '0;
        end else if (cmd_i.step) begin
            mask_q <= {1'b0, mask_q[NUM_ELEM-1:1]};
            if (mask_q[0]) slot_q <= slot_q + 1'b1;
        end
    end

    assign wr_en_o   = cmd_i.step & mask_q[0];
    assign wr_slot_o = slot_q[POS_W-1:0];
    assign count_o   = slot_q;
endmodule

// File: rtl/cidx_gen.sv
module cidx_gen
    import cidx_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 64,
    parameter int unsigned IDX_W    = 64,
    localparam int unsigned POS_W   = $clog2(NUM_ELEM),
    localparam int unsigned CNT_W   = cnt_width(NUM_ELEM)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [IDX_W-1:0]    stride_i,
    input  logic [NUM_ELEM-1:0] mask_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [CNT_W-1:0]    count_o,
    output logic                wr_en_o,
    output logic [POS_W-1:0]    wr_slot_o,
    output logic [IDX_W-1:0]    wr_data_o
);
    seq_cmd_t         cmd;
    logic [IDX_W-1:0] stride_q;

    cidx_ctrl #(.NUM_ELEM(NUM_ELEM)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cmd_o   (cmd),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    cidx_ramp #(.IDX_W(IDX_W)) u_ramp (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .stride_i (stride_i),
        .stride_o (stride_q),
        .value_o  (wr_data_o)
    );

    cidx_pack #(.NUM_ELEM(NUM_ELEM)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd),
        .mask_i    (mask_i),
        .wr_en_o   (wr_en_o),
        .wr_slot_o (wr_slot_o),
        .count_o   (count_o)
    );
endmodule

// File: rtl/cidx_gen_chk.sv
module cidx_gen_chk #(
    parameter int unsigned IDX_W = 64,
    parameter int unsigned POS_W = 6,
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             wr_en,
    input logic [POS_W-1:0] wr_slot,
    input logic [CNT_W-1:0] count,
    input logic [IDX_W-1:0] wr_data,
    input logic [IDX_W-1:0] stride
);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    // R5
    write_in_walk_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);
    // R4
    slot_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $past(wr_en)) |-> (wr_slot == $past(wr_slot) + 1'b1));
    // R4
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(wr_en)) |-> (wr_slot == $past(wr_slot)));
    // R3
    ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (wr_data == $past(wr_data) + stride));
    // R9
    stride_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(stride));
    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && !$past(start)) |-> $stable(count));
endmodule

bind cidx_gen cidx_gen_chk #(.IDX_W(IDX_W), .POS_W(POS_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start_i),
    .busy    (busy_o),
    .done    (done_o),
    .wr_en   (wr_en_o),
    .wr_slot (wr_slot_o),
    .count   (count_o),
    .wr_data (wr_data_o),
    .stride  (stride_q)
);

// File: tb/cidx_gen_tb.sv
`timescale 1ns/1ps
module cidx_gen_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [63:0] stride_i;
    logic [63:0] mask_i;
    logic        busy_o, done_o, wr_en_o;
    logic [6:0]  count_o;
    logic [5:0]  wr_slot_o;
    logic [63:0] wr_data_o;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    cidx_gen u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .stride_i(stride_i), .mask_i(mask_i),
        .busy_o(busy_o), .done_o(done_o), .count_o(count_o),
        .wr_en_o(wr_en_o), .wr_slot_o(wr_slot_o), .wr_data_o(wr_data_o)
    );

    function automatic int unsigned popc(input logic [63:0] m);
        int unsigned c = 0;
        for (int i = 0; i < 64; i++) c += m[i];
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one operation; disturb: 1 = start mid-walk, 2 = reset mid-walk
    task automatic run_op(input logic [63:0] m, input logic [63:0] s, input int disturb);
        int unsigned wr_cnt = 0;
        int unsigned pc = popc(m);
        bit aborted = 0;
        @(negedge clk);
        start_i = 1'b1; stride_i = s; mask_i = m;
        @(negedge clk);
        start_i = 1'b0; stride_i = ~s; mask_i = ~m;
        for (int n = 0; n < 64; n++) begin
            if (!aborted) begin
                chk(busy_o == 1'b1 && done_o == 1'b0, "R2 busy", {62'd0, busy_o, done_o}, 64'd2);
                if (m[n]) begin
                    chk(wr_en_o == 1'b1, "R5 write present", {63'd0, wr_en_o}, 64'd1);
                    chk(wr_slot_o == 6'(wr_cnt), "R4 slot", {58'd0, wr_slot_o}, 64'(wr_cnt));
                    chk(wr_data_o == 64'(n) * s, (m == '1) ? "R6 ramp" : "R3 data", wr_data_o, 64'(n) * s);
                    wr_cnt++;
                end else begin
                    chk(wr_en_o == 1'b0, "R5 no write", {63'd0, wr_en_o}, 64'd0);
                end
            end
            if (disturb == 1 && n == 10) begin
                start_i = 1'b1;
            end else if (disturb == 2 && n == 20) begin
                rst = 1'b1;
            end else begin
                start_i = 1'b0;
                rst = 1'b0;
            end
            @(negedge clk);
            if (disturb == 2 && n == 20) begin
                rst = 1'b0;
                aborted = 1;
                chk(busy_o == 1'b0 && done_o == 1'b0 && wr_en_o == 1'b0, "R10 abort",
                    {61'd0, busy_o, done_o, wr_en_o}, 64'd0);
            end
            if (aborted) begin
                chk(busy_o == 1'b0 && done_o == 1'b0 && wr_en_o == 1'b0, "R10 idle",
                    {61'd0, busy_o, done_o, wr_en_o}, 64'd0);
                if (n == 25) break;
            end
        end
        start_i = 1'b0;
        if (!aborted) begin
            chk(done_o == 1'b1 && busy_o == 1'b0, "R7 done", {62'd0, busy_o, done_o}, 64'd1);
            chk(count_o == 7'(pc), "R8 count", {57'd0, count_o}, 64'(pc));
            chk(wr_cnt == pc, "R4 writes", 64'(wr_cnt), 64'(pc));
            @(negedge clk);
            chk(done_o == 1'b0, "R7 single", {63'd0, done_o}, 64'd0);
            @(negedge clk);
            chk(count_o == 7'(pc), "R8 hold", {57'd0, count_o}, 64'(pc));
            if (disturb == 1) chk(1'b1, "R9 ignored start", 64'd0, 64'd0);
        end
    endtask

    initial begin
        logic [63:0] rm, rs;
        void'($urandom(32'd2024));
        rst = 1'b1; start_i = 1'b0; stride_i = '0; mask_i = '0;
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && wr_en_o == 0 && count_o == 0, "R1 reset",
            {57'd0, count_o}, 64'd0);
        rst = 1'b0;
        run_op('1, 64'd8, 0);
        run_op('1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        run_op('0, 64'd5, 0);
        run_op(64'h8000_0000_0000_0000, 64'd3, 0);
        run_op(64'h1, 64'd7, 0);
        run_op(64'hAAAA_AAAA_AAAA_AAAA, 64'h8000_0000_0000_0001, 0);
        run_op(64'h0F0F_00FF_1234_8001, 64'd11, 1);
        run_op(64'hFFFF_0000_FFFF_0000, 64'd13, 2);
        for (int k = 0; k < 20; k++) begin
            rm = {$urandom, $urandom};
            if (k % 3 == 0) rm = rm & {$urandom, $urandom};
            rs = {$urandom, $urandom};
            run_op(rm, rs, (k % 5 == 4) ? 1 : 0);
        end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule